// File: doc/BRIEF.md
# Memory Tag Check Unit

This block guards a small on-chip memory by giving every 16-byte granule a 4-bit lock tag and checking each ordinary load or store against the key tag carried in the upper byte of its 64-bit address. A requester presents one request per cycle. The request can be a checked data access, a tag-only write, a tag write that also clears the granule, a tag write that covers two neighbouring granules, a combined tag-and-data write, or a tag read. One cycle later the block returns a registered response.

When a key does not match its lock, the block acts according to a mode input. In precise mode it faults that exact access: the store is dropped, or the load returns zero. In imprecise mode it lets the access finish and records the first failing address in a sticky log. Software empties that log with a clear strobe. Accesses flagged as stack-pointer-plus-immediate skip the check entirely.

Top module: `mtc_unit`

## Requirements
- R1: After reset, resp_valid, resp_fault and async_flag are 0, and every granule holds tag 0 and all-zero data.
- R2: The key tag is address bits [59:56]. The granule is chosen by address bits [4+IW-1:4] only. Bits [3:0] and all bits above the index, including the rest of the top byte, do not affect which granule is reached.
- R3: Operation code 2 (tag set) writes the key tag into the addressed granule and leaves its data unchanged. No tag operation (codes 2 to 6) is ever checked or faulted.
- R4: Operation code 3 (tag set and zero) writes the key tag and sets the granule's 128 data bits to zero.
- R5: Operation code 4 (tag pair) writes the key tag into the addressed granule and into the next one. The index wraps modulo the granule count. Data in both granules is unchanged.
- R6: Operation code 5 (tag and data) writes the key tag and the 128-bit write data into the granule.
- R7: Operation code 6 (tag read) returns the granule's tag on resp_tag one cycle later.
- R8: With mode_async=0, a load (code 0) or store (code 1) whose key differs from the lock sets resp_fault one cycle later. A faulting load returns zero data, and a faulting store leaves memory unchanged.
- R9: With mode_async=1, a mismatching access completes normally without resp_fault. It sets async_flag and captures its full address in async_addr, but only if the flag was clear. Later failures leave the captured address unchanged.
- R10: async_clr clears async_flag on the next edge. If a failing access arrives in the same cycle as the clear, the failure wins: the flag stays set and the new address is captured.
- R11: A load or store with req_sp_imm=1 is never checked, in either mode.
- R12: resp_valid follows req_valid by exactly one cycle. A matching load returns the granule's data on resp_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 load, 1 store, 2 tag set, 3 tag set+zero, 4 tag pair, 5 tag+data, 6 tag read) |
| req_addr | input | 64 | Access address with key tag in bits [59:56] |
| req_wdata | input | 128 | Granule write data |
| req_sp_imm | input | 1 | Access is stack-pointer plus immediate (unchecked) |
| mode_async | input | 1 | 0 = precise faults, 1 = imprecise logging |
| async_clr | input | 1 | Clear strobe for the sticky log |
| resp_valid | output | 1 | Response present |
| resp_fault | output | 1 | Precise tag fault for the answered access |
| resp_rdata | output | 128 | Load data |
| resp_tag | output | 4 | Tag returned by a tag read |
| async_flag | output | 1 | Sticky imprecise failure flag |
| async_addr | output | 64 | Address of the first logged failure |

## Verification
The clear strobe and a new imprecise failure can land on the same clock edge. The bench provokes this by driving async_clr high alongside a mismatching load. It then expects the flag to remain set and to hold the new address, not the one logged earlier. A second collision arises when a tag-pair write starts on the last granule. The bench judges the wrap by reading back the tag of granule zero and loading its unchanged data with the new key.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int GRAN_BYTES = 16;
  localparam int DATA_W     = GRAN_BYTES * 8;
  localparam int TAG_W      = 4;
  localparam int KEY_LSB    = 56;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_TAGSET  = 3'd2,
    OP_TAGZERO = 3'd3,
    OP_TAGPAIR = 3'd4,
    OP_TAGDATA = 3'd5,
    OP_TAGREAD = 3'd6,
    OP_NONE    = 3'd7
  } mtc_op_e;

  function automatic logic [TAG_W-1:0] key_of(input logic [63:0] a);
    return a[KEY_LSB +: TAG_W];
  endfunction

  function automatic logic is_checked(input mtc_op_e op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

  function automatic logic writes_tag(input mtc_op_e op);
    return (op == OP_TAGSET) || (op == OP_TAGZERO) ||
           (op == OP_TAGPAIR) || (op == OP_TAGDATA);
  endfunction
endpackage

// File: rtl/mtc_tag_store.sv
module mtc_tag_store #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [IW-1:0] idx_a,
  input  logic [3:0]    tag_a,
  input  logic          we_b,
  input  logic [IW-1:0] idx_b,
  input  logic [3:0]    tag_b,
  input  logic [IW-1:0] rd_idx,
  output logic [3:0]    rd_tag
);
  logic [3:0] locks [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) locks[i] <= '0;
    end else begin
      if (we_a) locks[idx_a] <= tag_a;
      if (we_b) locks[idx_b] <= tag_b;
    end
  end

  assign rd_tag = locks[rd_idx];
endmodule

// File: rtl/mtc_data_store.sv
module mtc_data_store #(
  parameter int N  = 16,
  parameter int IW = $clog2(N),
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] cells [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cells[i] <= '0;
    end else if (we) begin
      cells[idx] <= wdata;
    end
  end

  assign rd_data = cells[idx];
endmodule

// File: rtl/mtc_check.sv
module mtc_check
  import mtc_pkg::*;
(
  input  logic       valid,
  input  mtc_op_e    op,
  input  logic       sp_imm,
  input  logic [3:0] key,
  input  logic [3:0] lock,
  output logic       mismatch
);
  always_comb begin
    mismatch = valid && is_checked(op) && !sp_imm && (key != lock);
  end
endmodule

// File: rtl/mtc_async_log.sv
module mtc_async_log (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fail,
  input  logic [63:0] fail_addr,
  input  logic        clr,
  output logic        flag,
  output logic [63:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      addr <= '0;
    end else if (fail && (!flag || clr)) begin
      flag <= 1'b1;
      addr <= fail_addr;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/mtc_unit.sv
module mtc_unit
  import mtc_pkg::*;
#(
  parameter int N_GRAN = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [63:0]   req_addr,
  input  logic [127:0]  req_wdata,
  input  logic          req_sp_imm,
  input  logic          mode_async,
  input  logic          async_clr,
  output logic          resp_valid,
  output logic          resp_fault,
  output logic [127:0]  resp_rdata,
  output logic [3:0]    resp_tag,
  output logic          async_flag,
  output logic [63:0]   async_addr
);
  localparam int IW = $clog2(N_GRAN);

  mtc_op_e       op;
  logic [IW-1:0] idx, idx_nx;
  logic [3:0]    key, lock;
  logic [127:0]  cell_q, cell_wdata;
  logic          mismatch, sync_fault, async_fail;
  logic          tag_we_a, tag_we_b, data_we;

  assign op     = mtc_op_e'(req_op);
  assign idx    = req_addr[4 +: IW];
  assign idx_nx = idx + IW'(1);
  assign key    = key_of(req_addr);

  mtc_check u_check (
    .valid(req_valid), .op(op), .sp_imm(req_sp_imm),
    .key(key), .lock(lock), .mismatch(mismatch)
  );

  assign sync_fault = mismatch && !mode_async;
  assign async_fail = mismatch && mode_async;

  assign tag_we_a   = req_valid && writes_tag(op);
  assign tag_we_b   = req_valid && (op == OP_TAGPAIR);
  assign data_we    = req_valid && (((op == OP_STORE) && !sync_fault) ||
                                    (op == OP_TAGZERO) || (op == OP_TAGDATA));
  assign cell_wdata = (op == OP_TAGZERO) ? '0 : req_wdata;

  mtc_tag_store #(.N(N_GRAN), .IW(IW)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .we_a(tag_we_a), .idx_a(idx), .tag_a(key),
    .we_b(tag_we_b), .idx_b(idx_nx), .tag_b(key),
    .rd_idx(idx), .rd_tag(lock)
  );

  mtc_data_store #(.N(N_GRAN), .IW(IW), .DW(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .we(data_we), .idx(idx),
    .wdata(cell_wdata), .rd_data(cell_q)
  );

  mtc_async_log u_log (
    .clk(clk), .rst_n(rst_n), .fail(async_fail), .fail_addr(req_addr),
    .clr(async_clr), .flag(async_flag), .addr(async_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_rdata <= '0;
      resp_tag   <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_fault <= sync_fault;
      resp_rdata <= (req_valid && (op == OP_LOAD) && !sync_fault) ? cell_q : '0;
      resp_tag   <= (req_valid && (op == OP_TAGREAD)) ? lock : '0;
    end
  end
endmodule

// File: rtl/mtc_unit_chk.sv
module mtc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_sp_imm,
  input logic [63:0] req_addr,
  input logic        mode_async,
  input logic        async_clr,
  input logic        resp_valid,
  input logic        resp_fault,
  input logic        async_flag,
  input logic [63:0] async_addr,
  input logic        sync_fault,
  input logic        async_fail,
  input logic        data_we
);
  assert_resp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  assert_no_spurious_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  assert_fault_has_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> resp_valid);
  assert_fault_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fault |-> !data_we);
  assert_async_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_async) |=> !resp_fault);
  assert_sp_unchecked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sp_imm) |=> !resp_fault);
  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (async_flag && !async_clr) |=> (async_flag && $stable(async_addr)));
  assert_fail_logs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (async_fail && (!async_flag || async_clr)) |=> (async_flag && async_addr == $past(req_addr)));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (async_clr && !async_fail) |=> !async_flag);
endmodule

bind mtc_unit mtc_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sp_imm(req_sp_imm),
  .req_addr(req_addr), .mode_async(mode_async), .async_clr(async_clr),
  .resp_valid(resp_valid), .resp_fault(resp_fault), .async_flag(async_flag),
  .async_addr(async_addr), .sync_fault(sync_fault), .async_fail(async_fail),
  .data_we(data_we)
);

// File: tb/tb_mtc_unit.sv
module tb_mtc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [63:0] req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic req_sp_imm = 1'b0;
  logic mode_async = 1'b0;
  logic async_clr = 1'b0;
  logic resp_valid, resp_fault, async_flag;
  logic [127:0] resp_rdata;
  logic [3:0] resp_tag;
  logic [63:0] async_addr;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [127:0] D1 = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
  localparam logic [127:0] D2 = 128'hA5A5_0000_FFFF_1234_DEAD_BEEF_CAFE_0001;
  localparam logic [127:0] D3 = 128'h0F0F_F0F0_0123_4567_89AB_CDEF_0000_0003;
  localparam logic [127:0] D4 = 128'h4444_4444_0000_0000_4444_4444_0000_0004;
  localparam logic [127:0] D5 = 128'h5555_AAAA_5555_AAAA_5555_AAAA_5555_0005;

  always #4 clk = ~clk;

  mtc_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_sp_imm(req_sp_imm),
    .mode_async(mode_async), .async_clr(async_clr), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_rdata(resp_rdata), .resp_tag(resp_tag),
    .async_flag(async_flag), .async_addr(async_addr)
  );

  // key in [59:56], granule in [7:4], junk elsewhere (R2)
  function automatic logic [63:0] mk(input logic [3:0] tag, input logic [3:0] gran,
                                     input logic [3:0] junk);
    return {junk, tag, {12{junk}}, gran, junk};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [63:0] a,
                       input logic [127:0] wd, input logic sp, input logic clr);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    req_sp_imm = sp; async_clr = clr;
    @(negedge clk);
    req_valid = 1'b0; req_sp_imm = 1'b0; async_clr = 1'b0;
    chk("R12 resp_valid", 128'(resp_valid), 128'd1);
  endtask

  task automatic t_reset;
    chk("R1 resp_valid", 128'(resp_valid), 128'd0);
    chk("R1 async_flag", 128'(async_flag), 128'd0);
    issue(3'd6, mk(4'h0, 4'd3, 4'h9), '0, 1'b0, 1'b0);
    chk("R1 tag zero", 128'(resp_tag), 128'd0);
    issue(3'd0, mk(4'h0, 4'd3, 4'h1), '0, 1'b0, 1'b0);
    chk("R1 data zero", resp_rdata, '0);
    chk("R1 no fault", 128'(resp_fault), 128'd0);
  endtask

  task automatic t_tagdata;
    issue(3'd5, mk(4'h5, 4'd2, 4'h3), D1, 1'b0, 1'b0);
    issue(3'd0, mk(4'h5, 4'd2, 4'hC), '0, 1'b0, 1'b0);
    chk("R6 data", resp_rdata, D1);
    chk("R12 match no fault", 128'(resp_fault), 128'd0);
    issue(3'd0, mk(4'h5, 4'd2, 4'h6), '0, 1'b0, 1'b0);
    chk("R2 other junk same granule", resp_rdata, D1);
  endtask

  task automatic t_tagset;
    issue(3'd2, mk(4'h9, 4'd2, 4'h0), 128'hFF, 1'b0, 1'b0);
    issue(3'd6, mk(4'h1, 4'd2, 4'hF), '0, 1'b0, 1'b0);
    chk("R7 tag read", 128'(resp_tag), 128'h9);
    chk("R3 tag op unchecked", 128'(resp_fault), 128'd0);
    issue(3'd0, mk(4'h9, 4'd2, 4'h7), '0, 1'b0, 1'b0);
    chk("R3 data kept", resp_rdata, D1);
  endtask

  task automatic t_tagzero;
    issue(3'd3, mk(4'h3, 4'd2, 4'hA), D5, 1'b0, 1'b0);
    issue(3'd0, mk(4'h3, 4'd2, 4'h2), '0, 1'b0, 1'b0);
    chk("R4 zeroed", resp_rdata, '0);
    chk("R4 new tag matches", 128'(resp_fault), 128'd0);
  endtask

  task automatic t_pair;
    issue(3'd5, mk(4'h1, 4'd15, 4'h0), D2, 1'b0, 1'b0);
    issue(3'd5, mk(4'h1, 4'd0, 4'h0), D3, 1'b0, 1'b0);
    issue(3'd4, mk(4'h7, 4'd15, 4'h4), '0, 1'b0, 1'b0);
    issue(3'd6, mk(4'h0, 4'd15, 4'h0), '0, 1'b0, 1'b0);
    chk("R5 first granule tag", 128'(resp_tag), 128'h7);
    issue(3'd6, mk(4'h0, 4'd0, 4'h0), '0, 1'b0, 1'b0);
    chk("R5 wrapped granule tag", 128'(resp_tag), 128'h7);
    issue(3'd0, mk(4'h7, 4'd0, 4'h0), '0, 1'b0, 1'b0);
    chk("R5 wrapped data kept", resp_rdata, D3);
    issue(3'd0, mk(4'h7, 4'd15, 4'h0), '0, 1'b0, 1'b0);
    chk("R5 first data kept", resp_rdata, D2);
  endtask

  task automatic t_sync;
    mode_async = 1'b0;
    issue(3'd5, mk(4'h2, 4'd4, 4'h0), D4, 1'b0, 1'b0);
    issue(3'd0, mk(4'h6, 4'd4, 4'h0), '0, 1'b0, 1'b0);
    chk("R8 load fault", 128'(resp_fault), 128'd1);
    chk("R8 load data blocked", resp_rdata, '0);
    issue(3'd1, mk(4'h6, 4'd4, 4'h0), D5, 1'b0, 1'b0);
    chk("R8 store fault", 128'(resp_fault), 128'd1);
    issue(3'd0, mk(4'h2, 4'd4, 4'h0), '0, 1'b0, 1'b0);
    chk("R8 store blocked", resp_rdata, D4);
    chk("R8 no async log", 128'(async_flag), 128'd0);
  endtask

  task automatic t_async;
    logic [63:0] a1;
    a1 = mk(4'h6, 4'd4, 4'hB);
    mode_async = 1'b1;
    issue(3'd0, a1, '0, 1'b0, 1'b0);
    chk("R9 no fault", 128'(resp_fault), 128'd0);
    chk("R9 load completes", resp_rdata, D4);
    chk("R9 flag", 128'(async_flag), 128'd1);
    chk("R9 addr", 128'(async_addr), 128'(a1));
    issue(3'd1, mk(4'h8, 4'd4, 4'h0), D5, 1'b0, 1'b0);
    issue(3'd0, mk(4'h2, 4'd4, 4'h0), '0, 1'b0, 1'b0);
    chk("R9 store completes", resp_rdata, D5);
    chk("R9 first addr kept", 128'(async_addr), 128'(a1));
  endtask

  task automatic t_clear;
    logic [63:0] a3;
    a3 = mk(4'hE, 4'd4, 4'h5);
    @(negedge clk); async_clr = 1'b1;
    @(negedge clk); async_clr = 1'b0;
    chk("R10 clear", 128'(async_flag), 128'd0);
    issue(3'd0, mk(4'hD, 4'd4, 4'h0), '0, 1'b0, 1'b0);
    chk("R10 relog", 128'(async_flag), 128'd1);
    issue(3'd0, a3, '0, 1'b0, 1'b1);
    chk("R10 collision flag", 128'(async_flag), 128'd1);
    chk("R10 collision addr", 128'(async_addr), 128'(a3));
  endtask

  task automatic t_sp;
    mode_async = 1'b0;
    issue(3'd0, mk(4'h6, 4'd4, 4'h0), '0, 1'b1, 1'b0);
    chk("R11 sp no fault", 128'(resp_fault), 128'd0);
    chk("R11 sp data", resp_rdata, D5);
    issue(3'd1, mk(4'hF, 4'd4, 4'h0), D1, 1'b1, 1'b0);
    issue(3'd0, mk(4'h2, 4'd4, 4'h0), '0, 1'b0, 1'b0);
    chk("R11 sp store written", resp_rdata, D1);
    @(negedge clk);
    chk("R12 idle no resp", 128'(resp_valid), 128'd0);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tagdata();
    t_tagset();
    t_tagzero();
    t_pair();
    t_sync();
    t_async();
    t_clear();
    t_sp();
    finish_run();
  end
endmodule